// File: doc/BRIEF.md
# Periodic Toggling-Bit Clearer

This block sits on one front-end data word stream and watches every bit position of the word on every clock. Some front-end chips insert a diagnostic bit that changes level at a fixed interval. Downstream hit detection would treat that bit as a real hit, so this block has to find it and remove it. Each bit position keeps its own tracker. The tracker remembers the last level, counts the cycles since the last level change, and counts how many level changes in a row arrived at exactly the expected interval.

When one position has gathered enough exact-interval changes, the block locks onto it. From then on it reports that position and raises a flag. The bit at that position is forced to zero in the output, and every other bit is passed through. The lock holds until reset. Several instances are placed side by side, one per chip or per data rate. The interval and the confirmation count are parameters, so a test can use small values.

A small state machine controls the block. Its states are PRIME, SEARCH and LOCKED:
- PRIME lasts one cycle after reset and only captures the reference levels.
- PRIME moves to SEARCH unconditionally.
- SEARCH moves to LOCKED as soon as any tracker reports confirmation, and otherwise stays in SEARCH.
- LOCKED stays in LOCKED until reset.

Top module: `flash_clearer`

## Requirements
- R1: While reset is sampled high, the next edge leaves `active_o` at 0, `data_o` at all zeros and `lock_idx_o` at 0.
- R2: While `active_o` is low, `data_o` equals `din_i` sampled one clock earlier, bit for bit.
- R3: The first clock after reset is released (state PRIME) only captures each bit's level as a reference. No level change is evaluated on that edge.
- R4: In SEARCH, a level change on a position counts toward confirmation only if it comes exactly `PERIOD` clocks after the previous level change on that same position. The first change seen on a position only starts the timing.
- R5: In SEARCH, a change that comes earlier or later than `PERIOD` clocks resets that position's count to zero. So does the absence of a change at the expected clock.
- R6: When a position records its `CONFIRM`-th counted change, the state moves from SEARCH to LOCKED on the next edge, and `active_o` rises on that same edge. For example, with `PERIOD`=6 and `CONFIRM`=3, a bit that starts at 1 in PRIME and flips every 6 words gives `active_o`=1 after the 26th word and not after the 25th.
- R7: For a word captured while `active_o` is high, the output bit at index `lock_idx_o` is 0, and all other output bits equal the captured input bits.
- R8: If several positions confirm on the same edge, the lowest bit index is locked.
- R9: Once `active_o` is high, it and `lock_idx_o` hold until reset. Activity on any other position, or the locked bit going quiet, has no effect on either.
- R10: `lock_idx_o` reports the binary index of the locked position. It reads 0 while not locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| din_i | input | WORD_W | Data word sampled every clock |
| data_o | output | WORD_W | Registered word with the locked bit cleared |
| active_o | output | 1 | High once a toggling position is locked |
| lock_idx_o | output | clog2(WORD_W) | Index of the locked position |

## Verification
Two things can land on the same edge.

The first is two positions confirming together. The bench starts bits 2 and 5 flipping in the same phase, so both trackers reach the confirmation count on the same edge. It then checks that the locked index is 2.

The second is lock entry coinciding with data capture. The word sampled on the edge where `active_o` rises must still come out unmasked, and the next word must be masked. A cycle-by-cycle reference model judges this on every word of every run. The model is written with absolute timestamps rather than counters.

// File: rtl/flashclr_pkg.sv
package flashclr_pkg;

    typedef enum logic [1:0] {
        FC_PRIME  = 2'd0,
        FC_SEARCH = 2'd1,
        FC_LOCKED = 2'd2
    } fc_state_e;

endpackage

// File: rtl/flashclr_lane.sv
// Per-bit tracker: last level, cycles since last change, run of exact-period changes.
module flashclr_lane #(
    parameter int PERIOD  = 3546,
    parameter int CONFIRM = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic load_i,
    input  logic eval_i,
    input  logic bit_i,
    output logic hit_o
);

    localparam int CNT_W = $clog2(PERIOD + 2);
    localparam int TOG_W = (CONFIRM > 1) ? $clog2(CONFIRM + 1) : 1;
    localparam logic [CNT_W-1:0] PER_C = CNT_W'(PERIOD);
    localparam logic [TOG_W-1:0] CNF_C = TOG_W'(CONFIRM);

    logic             prev_q;
    logic             armed_q;
    logic [CNT_W-1:0] cnt_q;
    logic [TOG_W-1:0] tog_q;
    logic             edge_seen;
    logic             on_time;

    assign edge_seen = (bit_i != prev_q);
    assign on_time   = armed_q && (cnt_q == PER_C);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= 1'b0;
            armed_q <= 1'b0;
            cnt_q   <= '0;
            tog_q   <= '0;
        end else if (load_i) begin
            prev_q <= bit_i;
        end else if (eval_i) begin
            prev_q <= bit_i;
            if (edge_seen) begin
                armed_q <= 1'b1;
                cnt_q   <= CNT_W'(1);
                if (on_time) begin
                    if (tog_q != CNF_C) tog_q <= tog_q + TOG_W'(1);
                end else begin
                    tog_q <= '0;
                end
            end else if (armed_q) begin
                if (cnt_q >= PER_C) tog_q <= '0;
                if (cnt_q <= PER_C) cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    assign hit_o = (tog_q == CNF_C);

endmodule

// File: rtl/flashclr_pick.sv
// Lowest-index-wins selection among confirming positions.
module flashclr_pick #(
    parameter int WORD_W = 8,
    parameter int IDX_W  = 3
) (
    input  logic [WORD_W-1:0] req_i,
    output logic              any_o,
    output logic [IDX_W-1:0]  idx_o
);

    always_comb begin
        any_o = |req_i;
        idx_o = '0;
        for (int i = WORD_W - 1; i >= 0; i--) begin
            if (req_i[i]) idx_o = IDX_W'(i);
        end
    end

endmodule

// File: rtl/flashclr_clear.sv
// Registered output stage that clears one selected bit.
module flashclr_clear #(
    parameter int WORD_W = 8,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] din_i,
    input  logic              clr_en_i,
    input  logic [IDX_W-1:0]  clr_idx_i,
    output logic [WORD_W-1:0] data_o
);

    logic [WORD_W-1:0] clr_bits;

    for (genvar b = 0; b < WORD_W; b++) begin : g_mask
        assign clr_bits[b] = clr_en_i && (clr_idx_i == IDX_W'(b));
    end

    always_ff @(posedge clk) begin
        if (rst) data_o <= '0;
        else     data_o <= din_i & ~clr_bits;
    end

endmodule

// File: rtl/flash_clearer.sv
module flash_clearer
    import flashclr_pkg::*;
#(
    parameter int WORD_W  = 8,
    parameter int PERIOD  = 3546,
    parameter int CONFIRM = 10,
    localparam int IDX_W  = (WORD_W > 1) ? $clog2(WORD_W) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] din_i,
    output logic [WORD_W-1:0] data_o,
    output logic              active_o,
    output logic [IDX_W-1:0]  lock_idx_o
);

    fc_state_e         state_q;
    fc_state_e         state_d;
    logic [WORD_W-1:0] hit;
    logic              any_hit;
    logic [IDX_W-1:0]  pick_idx;
    logic              in_prime;
    logic              in_search;

    assign in_prime  = (state_q == FC_PRIME);
    assign in_search = (state_q == FC_SEARCH);

    for (genvar b = 0; b < WORD_W; b++) begin : g_lane
        flashclr_lane #(
            .PERIOD  (PERIOD),
            .CONFIRM (CONFIRM)
        ) u_lane (
            .clk    (clk),
            .rst    (rst),
            .load_i (in_prime),
            .eval_i (in_search),
            .bit_i  (din_i[b]),
            .hit_o  (hit[b])
        );
    end

    flashclr_pick #(
        .WORD_W (WORD_W),
        .IDX_W  (IDX_W)
    ) u_pick (
        .req_i (hit),
        .any_o (any_hit),
        .idx_o (pick_idx)
    );

    // next-state decode
    always_comb begin
        unique case (state_q)
            FC_PRIME:  state_d = FC_SEARCH;
            FC_SEARCH: state_d = any_hit ? FC_LOCKED : FC_SEARCH;
            FC_LOCKED: state_d = FC_LOCKED;
            default:   state_d = FC_PRIME;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= FC_PRIME;
        else     state_q <= state_d;
    end

    // outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            active_o   <= 1'b0;
            lock_idx_o <= '0;
        end else if (in_search && (state_d == FC_LOCKED)) begin
            active_o   <= 1'b1;
            lock_idx_o <= pick_idx;
        end
    end

    flashclr_clear #(
        .WORD_W (WORD_W),
        .IDX_W  (IDX_W)
    ) u_clear (
        .clk       (clk),
        .rst       (rst),
        .din_i     (din_i),
        .clr_en_i  (active_o),
        .clr_idx_i (lock_idx_o),
        .data_o    (data_o)
    );

endmodule

// File: rtl/flash_clearer_chk.sv
module flash_clearer_chk #(
    parameter int WORD_W = 8,
    parameter int IDX_W  = 3
) (
    input logic              clk,
    input logic              rst,
    input logic [WORD_W-1:0] din_i,
    input logic [WORD_W-1:0] data_o,
    input logic              active_o,
    input logic [IDX_W-1:0]  lock_idx_o
);

    logic [WORD_W-1:0] clr_mask;
    assign clr_mask = active_o ? (WORD_W'(1) << lock_idx_o) : '0;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!active_o && (data_o == '0) && (lock_idx_o == '0)));

    // R2
    idle_pass_chk: assert property (@(posedge clk) disable iff (rst)
        !active_o |=> (data_o == $past(din_i)));

    // R7
    locked_bit_clear_chk: assert property (@(posedge clk) disable iff (rst)
        active_o |=> (data_o[lock_idx_o] == 1'b0));

    // R7
    other_bits_pass_chk: assert property (@(posedge clk) disable iff (rst)
        active_o |=> (((data_o ^ $past(din_i)) & ~$past(clr_mask)) == '0));

    // R9
    sticky_lock_chk: assert property (@(posedge clk) disable iff (rst)
        active_o |=> active_o);

    // R9
    idx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        active_o |=> $stable(lock_idx_o));

    // R10
    idle_idx_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !active_o |-> (lock_idx_o == '0));

endmodule

bind flash_clearer flash_clearer_chk #(
    .WORD_W (WORD_W),
    .IDX_W  (IDX_W)
) u_flash_clearer_chk (
    .clk        (clk),
    .rst        (rst),
    .din_i      (din_i),
    .data_o     (data_o),
    .active_o   (active_o),
    .lock_idx_o (lock_idx_o)
);

// File: tb/test_flash_clearer.sv
module test_flash_clearer;

    localparam int W = 8;
    localparam int P = 6;
    localparam int C = 3;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] din = '0;
    logic [W-1:0] data_o;
    logic         active_o;
    logic [2:0]   lock_idx_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // reference model state (timestamps, not counters)
    int           m_state;
    int           m_idx;
    bit           m_active;
    logic [W-1:0] m_data;
    logic [W-1:0] m_prev;
    int           m_last [W];
    bit           m_armed[W];
    int           m_tog  [W];
    int           m_n;

    always #5 clk = ~clk;

    flash_clearer #(.WORD_W(W), .PERIOD(P), .CONFIRM(C)) i_flash_clearer (
        .clk        (clk),
        .rst        (rst),
        .din_i      (din),
        .data_o     (data_o),
        .active_o   (active_o),
        .lock_idx_o (lock_idx_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic model_edge(input logic [W-1:0] x, input logic r);
        logic [W-1:0] nd;
        if (r) begin
            m_state = 0; m_idx = 0; m_active = 0; m_data = '0; m_prev = '0; m_n = 0;
            for (int b = 0; b < W; b++) begin
                m_last[b] = 0; m_armed[b] = 0; m_tog[b] = 0;
            end
            return;
        end
        m_n++;
        nd = (m_state == 2) ? (x & ~(W'(1) << m_idx)) : x;
        if (m_state == 0) begin
            m_prev  = x;
            m_state = 1;
        end else if (m_state == 1) begin
            for (int b = W - 1; b >= 0; b--) begin
                if (m_tog[b] == C) begin
                    m_state = 2;
                    m_idx   = b;
                end
            end
            for (int b = 0; b < W; b++) begin
                if (x[b] != m_prev[b]) begin
                    if (m_armed[b] && (m_n - m_last[b] == P))
                        m_tog[b] = (m_tog[b] < C) ? m_tog[b] + 1 : C;
                    else
                        m_tog[b] = 0;
                    m_last[b]  = m_n;
                    m_armed[b] = 1;
                end else if (m_armed[b] && (m_n - m_last[b] >= P)) begin
                    m_tog[b] = 0;
                end
            end
            m_prev = x;
        end
        m_data   = nd;
        m_active = (m_state == 2);
    endtask

    task automatic step(input logic [W-1:0] x);
        din = x;
        @(posedge clk);
        #2;
        model_edge(x, rst);
        chk((data_o == m_data) && (active_o == m_active) && (lock_idx_o == 3'(m_idx)),
            m_active ? "R7 word" : "R2 word",
            {active_o, lock_idx_o, data_o}, {m_active, 3'(m_idx), m_data});
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step('0);
        step(8'h5A);
        chk((active_o == 1'b0) && (data_o == '0) && (lock_idx_o == '0), "R1 reset",
            {active_o, lock_idx_o, data_o}, 0);
        rst = 1'b0;
    endtask

    // words k_from..k_to; flashing bits start at 1, flip every P words; slip adds one late word
    task automatic run_flash(input logic [W-1:0] fmask, input logic [W-1:0] base,
                             input logic [W-1:0] fast, input int k_from, input int k_to,
                             input int slip_at);
        for (int k = k_from; k < k_to; k++) begin
            int kk;
            logic [W-1:0] w;
            kk = (slip_at >= 0 && k >= slip_at) ? k - 1 : k;
            w  = (base & ~fmask) | ((((kk / P) % 2) == 0) ? fmask : '0);
            if (k % 2 == 1) w = w ^ fast;
            step(w);
        end
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        // R3 R4 R6 R10: sweep every position
        for (int p = 0; p < W; p++) begin
            logic [W-1:0] fm;
            logic [W-1:0] fs;
            fm = W'(1) << p;
            fs = W'(1) << ((p + 3) % W);
            do_reset();
            run_flash(fm, 8'hA5, fs, 0, 25, -1);
            chk(active_o == 1'b0, "R3/R4/R6 not yet locked", active_o, 0);
            run_flash(fm, 8'hA5, fs, 25, 26, -1);
            chk(active_o == 1'b1, "R6 lock edge", active_o, 1);
            chk(lock_idx_o == 3'(p), "R10 index", lock_idx_o, p);
            step(8'hFF);
            step(8'hFF);
            chk(data_o == (8'hFF & ~fm), "R7 clear", data_o, 8'hFF & ~fm);
        end

        // R5: one late change delays lock
        do_reset();
        run_flash(8'h10, 8'h00, 8'h00, 0, 26, 14);
        chk(active_o == 1'b0, "R5 late change resets count", active_o, 0);
        run_flash(8'h10, 8'h00, 8'h00, 26, 60, 14);
        chk(active_o == 1'b1 && lock_idx_o == 3'd4, "R5 later lock", {active_o, lock_idx_o}, {1'b1, 3'd4});

        // R8: two positions confirm on the same edge
        do_reset();
        run_flash(8'h24, 8'h00, 8'h01, 0, 30, -1);
        chk(lock_idx_o == 3'd2 && active_o, "R8 lowest index", lock_idx_o, 2);

        // R9: lock is sticky; another flashing bit is ignored
        run_flash(8'h40, 8'h00, 8'h00, 3, 60, -1);
        chk(active_o == 1'b1 && lock_idx_o == 3'd2, "R9 held lock", {active_o, lock_idx_o}, {1'b1, 3'd2});
        step(8'h44);
        step(8'h44);
        chk(data_o == 8'h40, "R9 other bit passes", data_o, 8'h40);

        // R1 once more after a locked run
        do_reset();
        step(8'h3C);
        chk(data_o == 8'h3C && !active_o, "R2 after reset", data_o, 8'h3C);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule